// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the directions of the most recently resolved branches, across the whole program. It also keeps a table of saturating counters. The table is addressed by low bits of the branch address. Within each addressed entry, the global history picks one of several counters, and that counter alone supplies the prediction and receives the training. Two parameters shape the block: `HIST_BITS` (m, the number of history bits) and `CTR_BITS` (n, the counter width). Setting m = 0 and n = 2 gives a plain table of 2-bit counters. Setting m = 1 and n = 1 gives one last-outcome bit per history context. Setting m = 2 and n = 2 gives four 2-bit counters per entry.

The fetch stage drives a PC onto the lookup port and reads back a direction in the same cycle. When a branch resolves, the back end presents its PC and its actual direction on the update port for one cycle. At the next clock edge one counter is trained and the history shifts. Branches whose index bits match share an entry; no tag separates them.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds its weakest not-taken value (binary 01 for n = 2, 0 for n = 1) and every history bit is 0 (not taken). Every lookup right after reset therefore predicts not taken.
- R2: The prediction is the most significant bit of the selected counter. For n = 2, the values 00 and 01 predict not taken and 10 and 11 predict taken.
- R3: For n ≥ 2, an update with outcome taken increments the selected counter unless it already holds all ones. An update with outcome not taken decrements it unless it already holds zero.
- R4: For n = 1, an update writes the resolved outcome into the selected counter, so the counter always holds the last outcome seen in that context.
- R5: An update changes only the selected counter. All other counters, including the other history contexts of the same entry, keep their values.
- R6: Every update shifts its outcome into the history as bit 0, the newest bit, with taken encoded as 1. Older bits move one place up and the oldest bit is dropped. The history records every resolved branch, whatever its address.
- R7: The selected counter is slot entry·2^m + history. The history value used is the one present in the cycle of the lookup or the update.
- R8: The entry number is PC bits [WORD_OFF + log2(ENTRIES) − 1 : WORD_OFF]. PCs that differ only outside these bits share counters.
- R9: The lookup output is combinational and uses the state that held before the clock edge. An update presented in the same cycle takes effect only after that edge. The history does not change in a cycle without an update.
- R10: With m = 0 and n = 2 the block behaves as a table of 2-bit counters indexed by address only. Updates of other branches do not affect the prediction for a branch.
- R11: The block supports m = 2, n = 2 with ENTRIES = 1024, which gives four 2-bit counters per entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | PC of the branch being fetched |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch (1 = taken) |

## Verification
Three configurations, (2,2) with 1024 entries, (0,2) and (1,1), receive the same branch stream. Each is compared against its own behavioural model of counters and history. Several patterns are used:
- A run of taken outcomes followed by a run of not-taken outcomes on one address walks a 2-bit counter through both saturation points and its hysteresis.
- A loop-style nine-taken, one-not-taken pattern separates a 1-bit counter, which mispredicts twice per loop, from a 2-bit counter, which mispredicts once.
- A pair of branches whose second outcome copies the first shows that only the correlating configurations learn the second branch.
- Directed cases cover aliasing between PCs, the isolation of history contexts and a lookup in the same cycle as an update. A long pseudo-random stream then exercises the shift order and all 1024 entries.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

    localparam int unsigned PC_W = 32;

    // Weakest not-taken counter value: MSB clear, every lower bit set.
    function automatic int unsigned weak_nt_val(input int unsigned bits);
        return (32'd1 << (bits - 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/corr_bpred_ctr.sv
module corr_bpred_ctr #(
    parameter int unsigned CB = 2
) (
    input  logic [CB-1:0] cur,
    input  logic          taken,
    output logic [CB-1:0] nxt
);

    localparam logic [CB-1:0] CTR_MAX = '1;
    localparam logic [CB-1:0] CTR_MIN = '0;

    // Saturating up/down step; for CB == 1 this degenerates to "store last outcome".
    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) begin
                nxt = cur + 1'b1;
            end
        end else begin
            if (cur != CTR_MIN) begin
                nxt = cur - 1'b1;
            end
        end
    end

endmodule

// File: rtl/corr_bpred_hist.sv
module corr_bpred_hist #(
    parameter int unsigned HB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_in,
    output logic [HB-1:0] hist_q
);

    typedef struct packed {
        logic [HB-1:0] hist;
    } hstate_t;

    hstate_t       st_d;
    hstate_t       st_q;
    logic [HB-1:0] shifted;

    generate
        if (HB == 1) begin : g_one
            assign shifted = shift_in;
        end else begin : g_many
            assign shifted = {st_q.hist[HB-2:0], shift_in};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hist = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_q = st_q.hist;

endmodule

// File: rtl/corr_bpred_table.sv
module corr_bpred_table
    import corr_bpred_pkg::*;
#(
    parameter int unsigned CB    = 2,
    parameter int unsigned SLOTS = 1024,
    parameter int unsigned IW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [CB-1:0] rd_ctr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_taken
);

    localparam logic [CB-1:0] WEAK_NT = CB'(weak_nt_val(CB));

    typedef struct packed {
        logic [SLOTS-1:0][CB-1:0] ctr;
    } tstate_t;

    localparam tstate_t TBL_RST = tstate_t'({SLOTS{WEAK_NT}});

    tstate_t       st_d;
    tstate_t       st_q;
    logic [CB-1:0] wr_cur;
    logic [CB-1:0] wr_nxt;

    assign wr_cur = st_q.ctr[wr_idx];

    corr_bpred_ctr #(.CB(CB)) u_step (
        .cur   (wr_cur),
        .taken (wr_taken),
        .nxt   (wr_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = wr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TBL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.ctr[rd_idx];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
    import corr_bpred_pkg::*;
#(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned CTR_BITS  = 2,
    parameter int unsigned ENTRIES   = 256,
    parameter int unsigned WORD_OFF  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    localparam int unsigned EW    = $clog2(ENTRIES);
    localparam int unsigned HW    = (HIST_BITS > 0) ? HIST_BITS : 1;
    localparam int unsigned IW    = EW + HIST_BITS;
    localparam int unsigned SLOTS = ENTRIES << HIST_BITS;
    localparam int unsigned HI_LO = WORD_OFF + EW;

    logic [EW-1:0]       lk_ent;
    logic [EW-1:0]       up_ent;
    logic [HW-1:0]       hist_q;
    logic [IW-1:0]       rd_idx;
    logic [IW-1:0]       wr_idx;
    logic [CTR_BITS-1:0] rd_ctr;
    logic                pc_bits_unused;

    assign lk_ent = lk_pc[WORD_OFF +: EW];
    assign up_ent = up_pc[WORD_OFF +: EW];
    assign pc_bits_unused = ^{lk_pc[PC_W-1:HI_LO], lk_pc[WORD_OFF-1:0],
                              up_pc[PC_W-1:HI_LO], up_pc[WORD_OFF-1:0]};

    generate
        if (HIST_BITS > 0) begin : g_corr
            corr_bpred_hist #(.HB(HIST_BITS)) u_hist (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (up_valid),
                .shift_in (up_taken),
                .hist_q   (hist_q)
            );
            assign rd_idx = {lk_ent, hist_q};
            assign wr_idx = {up_ent, hist_q};
        end else begin : g_plain
            assign hist_q = '0;
            assign rd_idx = lk_ent;
            assign wr_idx = up_ent;
        end
    endgenerate

    corr_bpred_table #(
        .CB    (CTR_BITS),
        .SLOTS (SLOTS),
        .IW    (IW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (up_valid),
        .wr_idx   (wr_idx),
        .wr_taken (up_taken)
    );

    assign lk_taken = rd_ctr[CTR_BITS-1];

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned HW        = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [31:0]   lk_pc,
    input logic          lk_taken,
    input logic          up_valid,
    input logic          up_taken,
    input logic [HW-1:0] hist
);

    // R1: history is all not-taken while reset is held
    assert_hist_cleared_R1: assert property (@(posedge clk)
        !rst_n |=> (hist == '0));

    // R9: no update, no history movement
    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(hist));

    // R9: with no update before the edge and a steady PC, the lookup is steady
    assert_lookup_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

    generate
        if (HIST_BITS > 0) begin : g_newest
            // R6: the resolved outcome becomes bit 0
            assert_hist_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> (hist[0] == $past(up_taken)));
        end
        if (HIST_BITS > 1) begin : g_shift
            // R6: older bits move up by one place
            assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> (hist[HW-1:1] == $past(hist[HW-2:0])));
        end
    endgenerate

endmodule

bind corr_bpred corr_bpred_chk #(
    .HIST_BITS (HIST_BITS),
    .HW        (HW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .hist     (hist_q)
);

// File: tb/corr_bpred_bench.sv
module corr_bpred_bench;

    localparam int CLK_P = 20;
    localparam int E22   = 1024;
    localparam int ES    = 16;

    logic        clk      = 1'b0;
    logic        rst_n    = 1'b0;
    logic [31:0] lk_pc    = '0;
    logic [31:0] up_pc    = '0;
    logic        up_valid = 1'b0;
    logic        up_taken = 1'b0;
    logic        p22, p02, p11;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic [1:0] m22 [E22*4];
    logic [1:0] m02 [ES];
    logic       m11 [ES*2];
    logic [1:0] h22;
    logic       h11;

    always #(CLK_P/2) clk = ~clk;

    corr_bpred #(.HIST_BITS(2), .CTR_BITS(2), .ENTRIES(E22)) u_corr_bpred (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p22),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    corr_bpred #(.HIST_BITS(0), .CTR_BITS(2), .ENTRIES(ES)) u_corr_bpred_m0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p02),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    corr_bpred #(.HIST_BITS(1), .CTR_BITS(1), .ENTRIES(ES)) u_corr_bpred_m1 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p11),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    function automatic int ent22(input logic [31:0] pc);
        return int'((pc >> 2) % E22);
    endfunction

    function automatic int ents(input logic [31:0] pc);
        return int'((pc >> 2) % ES);
    endfunction

    function automatic logic [1:0] sat2(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < E22*4; i++) m22[i] = 2'b01;
        for (int i = 0; i < ES; i++) m02[i] = 2'b01;
        for (int i = 0; i < ES*2; i++) m11[i] = 1'b0;
        h22 = 2'b00;
        h11 = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        up_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_all(input string tag);
        chk(tag, "(2,2)", p22, m22[ent22(lk_pc)*4 + int'(h22)][1]);
        chk(tag, "(0,2)", p02, m02[ents(lk_pc)][1]);
        chk(tag, "(1,1)", p11, m11[ents(lk_pc)*2 + int'(h11)]);
    endtask

    task automatic peek(input logic [31:0] pc, input string tag);
        @(negedge clk);
        up_valid = 1'b0;
        lk_pc    = pc;
        #2;
        check_all(tag);
    endtask

    // lookup and resolve one branch in the same cycle
    task automatic branch(input logic [31:0] pc, input logic t, input string tag);
        int i22, i02, i11;
        @(negedge clk);
        lk_pc    = pc;
        up_pc    = pc;
        up_taken = t;
        up_valid = 1'b1;
        #2;
        check_all(tag);
        i22 = ent22(pc)*4 + int'(h22);
        i02 = ents(pc);
        i11 = ents(pc)*2 + int'(h11);
        @(posedge clk);
        #1;
        m22[i22] = sat2(m22[i22], t);
        m02[i02] = sat2(m02[i02], t);
        m11[i11] = t;
        h22 = {h22[0], t};
        h11 = t;
        up_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        peek(32'h0000_0000, "R1");
        chk("R1", "(2,2) literal", p22, 1'b0);
        peek(32'h0000_1234, "R1");
        peek(32'hFFFF_FFFC, "R1");
        chk("R1", "(1,1) literal", p11, 1'b0);
    endtask

    task automatic t_saturate();
        do_reset();
        branch(32'h40, 1'b1, "R3");
        peek(32'h40, "R2");
        chk("R2", "01->10 predicts taken", p02, 1'b1);
        for (int i = 0; i < 4; i++) branch(32'h40, 1'b1, "R3");
        branch(32'h40, 1'b0, "R3");
        peek(32'h40, "R3");
        chk("R3", "11->10 still taken", p02, 1'b1);
        branch(32'h40, 1'b0, "R3");
        peek(32'h40, "R3");
        chk("R3", "10->01 not taken", p02, 1'b0);
        for (int i = 0; i < 5; i++) branch(32'h40, 1'b0, "R3");
        branch(32'h40, 1'b1, "R3");
        peek(32'h40, "R3");
        chk("R3", "00->01 not taken", p02, 1'b0);
        branch(32'h48, 1'b0, "R10");
        peek(32'h40, "R10");
        chk("R10", "other branch no effect", p02, 1'b0);
        branch(32'h40, 1'b1, "R3");
        peek(32'h40, "R3");
        chk("R3", "01->10 taken", p02, 1'b1);
    endtask

    task automatic t_loop();
        do_reset();
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 9; i++) branch(32'h80, 1'b1, "R4");
            branch(32'h80, 1'b0, "R4");
        end
    endtask

    task automatic t_correlate();
        logic [7:0] lf = 8'h5A;
        logic       x;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            x  = lf[0];
            branch(32'h200, x, "R7");
            peek(32'h204, "R7");
            if (i >= 12) chk("R7", "(1,1) follows correlated branch", p11, x);
            branch(32'h204, x, "R7");
        end
    endtask

    task automatic t_isolate();
        do_reset();
        branch(32'h504, 1'b1, "R5");
        branch(32'h300, 1'b1, "R5");
        branch(32'h508, 1'b0, "R5");
        peek(32'h300, "R5");
        chk("R5", "(1,1) ctx0 untouched", p11, 1'b0);
        branch(32'h504, 1'b1, "R5");
        peek(32'h300, "R5");
        chk("R5", "(1,1) ctx1 trained", p11, 1'b1);
    endtask

    task automatic t_alias();
        do_reset();
        branch(32'h40, 1'b1, "R8");
        branch(32'h40, 1'b1, "R8");
        peek(32'h40 + ES*4, "R8");
        chk("R8", "(0,2) alias shares counter", p02, 1'b1);
        peek(32'h44, "R8");
        chk("R8", "(0,2) neighbour entry", p02, 1'b0);
        peek(32'h41, "R8");
        chk("R8", "(0,2) offset bits ignored", p02, 1'b1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        @(negedge clk);
        lk_pc    = 32'h40;
        up_pc    = 32'h40;
        up_taken = 1'b1;
        up_valid = 1'b1;
        #2;
        chk("R9", "(0,2) before edge", p02, 1'b0);
        @(posedge clk);
        #2;
        up_valid = 1'b0;
        chk("R9", "(0,2) after edge", p02, 1'b1);
        m02[ents(32'h40)] = 2'b10;
        m22[ent22(32'h40)*4] = 2'b10;
        m11[ents(32'h40)*2] = 1'b1;
        h22 = 2'b01;
        h11 = 1'b1;
        peek(32'h40, "R9");
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            branch({18'd0, lf[11:0], 2'b00} + ((i % 3 == 0) ? 32'd0 : 32'h4000),
                   lf[2] | (lf[7] & lf[9]), (i % 2 == 0) ? "R6" : "R11");
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        t_reset();
        t_saturate();
        t_loop();
        t_correlate();
        t_isolate();
        t_alias();
        t_same_cycle();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule